// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the entrance of the execute stage of a five-stage load/store pipeline. For each of the two ALU source operands it decides whether the register-file value captured at decode is still current, or whether a younger result further down the pipeline must replace it. Two newer producers are considered: the instruction one ahead, whose ALU result sits in the execute/memory register, and the instruction two ahead, whose write-back value sits in the memory/write-back register. The write-back value is itself chosen between memory read data and the ALU result by the load flag carried in that register.

The block is purely combinational: register numbers, write flags and data go in, and the two 2-bit selects and the two resolved operands come out in the same cycle. No data stream crosses its boundary, so there is no valid/ready handshake and no back-pressure; all pins are plain control and data. The second operand is also the source of a store's write data, so a store reading a just-produced register gets the bypassed value. Stalls for load-use dependencies and branch handling are left to other blocks.

Top module: `opfwd_unit`

## Requirements
- R1: An operand's select is 2'b10 (take the execute/memory result) when the execute/memory write flag is 1, its destination register is not 0, and its destination equals that operand's source register.
- R2: An operand's select is 2'b01 (take the write-back value) when the memory/write-back write flag is 1, its destination is not 0, it equals the operand's source register, and the R1 condition does not hold for that operand.
- R3: When both producers target the operand's source register and both qualify, the select is 2'b10, so the younger producer wins.
- R4: In every other case, including a destination of register 0 or a clear write flag, the select is 2'b00 (take the register-file value).
- R5: The selects for operand A and operand B are decided independently, each from its own source register only.
- R6: Each operand output equals the register-file value, the execute/memory result or the write-back value according to its select being 00, 10 or 01.
- R7: The write-back value is the memory read data when the load flag of the memory/write-back register is 1, and the ALU result held there otherwise.
- R8: Selects and operands follow the inputs in the same cycle, with no register on any path.
- R9: A select never takes the value 2'b11.
- R10: Operand B, which also feeds store write data, carries the bypassed value under the same rules as operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_reg | input | 5 | Source register number of operand A in the execute stage |
| src_b_reg | input | 5 | Source register number of operand B in the execute stage |
| src_a_rf | input | 32 | Register-file value of operand A latched at decode |
| src_b_rf | input | 32 | Register-file value of operand B latched at decode |
| exm_wr_en | input | 1 | Execute/memory instruction writes a register |
| exm_dst | input | 5 | Destination register of the execute/memory instruction |
| exm_result | input | 32 | ALU result held in the execute/memory register |
| mwb_wr_en | input | 1 | Memory/write-back instruction writes a register |
| mwb_dst | input | 5 | Destination register of the memory/write-back instruction |
| mwb_mem_to_reg | input | 1 | Memory/write-back instruction writes loaded data |
| mwb_alu_result | input | 32 | ALU result held in the memory/write-back register |
| mwb_mem_data | input | 32 | Memory read data held in the memory/write-back register |
| sel_a | output | 2 | Bypass select for operand A (00 file, 10 exe/mem, 01 write-back) |
| sel_b | output | 2 | Bypass select for operand B, same encoding |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B, also the store write data |

## Verification
Every result of this block is due in the same cycle as the inputs that cause it, zero clock edges later. The bench therefore changes the inputs just after a rising edge and compares all four outputs against its own behavioural model at the following falling edge, once settled, so that each comparison sees exactly the stimulus applied half a period before. Directed patterns cover register 0, cleared write flags, both producers matching, and the load flag, and a long run with small register numbers creates frequent overlaps between the two operands and both producers.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam int OPFWD_NUM_OPS = 2;

  typedef enum logic [1:0] {
    FWD_FROM_RF  = 2'b00,
    FWD_FROM_MWB = 2'b01,
    FWD_FROM_EXM = 2'b10
  } fwd_sel_t;
endpackage

// File: rtl/opfwd_wb_pick.sv
module opfwd_wb_pick #(
  parameter int DATA_W = 32
) (
  input  logic              mem_to_reg,
  input  logic [DATA_W-1:0] alu_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] wb_val
);
  // Value the older producer is about to write back (R7)
  always_comb begin
    wb_val = mem_to_reg ? mem_val : alu_val;
  end
endmodule

// File: rtl/opfwd_sel_logic.sv
module opfwd_sel_logic
  import opfwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_reg,
  input  logic             exm_wr_en,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             mwb_wr_en,
  input  logic [REG_W-1:0] mwb_dst,
  output fwd_sel_t         sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exm_hit;
  logic mwb_hit;

  always_comb begin
    exm_hit = exm_wr_en && (exm_dst != ZERO_REG) && (exm_dst == src_reg);
    mwb_hit = mwb_wr_en && (mwb_dst != ZERO_REG) && (mwb_dst == src_reg);
    // younger producer takes precedence over the older one
    if (exm_hit)      sel = FWD_FROM_EXM;
    else if (mwb_hit) sel = FWD_FROM_MWB;
    else              sel = FWD_FROM_RF;
  end
endmodule

// File: rtl/opfwd_operand_mux.sv
module opfwd_operand_mux
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_t          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      FWD_FROM_EXM: opnd = exm_val;
      FWD_FROM_MWB: opnd = wb_val;
      default:      opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a_reg,
  input  logic [REG_W-1:0]  src_b_reg,
  input  logic [DATA_W-1:0] src_a_rf,
  input  logic [DATA_W-1:0] src_b_rf,
  input  logic              exm_wr_en,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic [DATA_W-1:0] exm_result,
  input  logic              mwb_wr_en,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic              mwb_mem_to_reg,
  input  logic [DATA_W-1:0] mwb_alu_result,
  input  logic [DATA_W-1:0] mwb_mem_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int NOPS = OPFWD_NUM_OPS;

  logic [REG_W-1:0]  op_src [NOPS];
  logic [DATA_W-1:0] op_rf  [NOPS];
  fwd_sel_t          op_sel [NOPS];
  logic [DATA_W-1:0] op_out [NOPS];
  logic [DATA_W-1:0] wb_val;

  always_comb begin
    op_src[0] = src_a_reg;
    op_src[1] = src_b_reg;
    op_rf[0]  = src_a_rf;
    op_rf[1]  = src_b_rf;
  end

  opfwd_wb_pick #(.DATA_W(DATA_W)) u_wb (
    .mem_to_reg (mwb_mem_to_reg),
    .alu_val    (mwb_alu_result),
    .mem_val    (mwb_mem_data),
    .wb_val     (wb_val)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    opfwd_sel_logic #(.REG_W(REG_W)) u_sel (
      .src_reg   (op_src[g]),
      .exm_wr_en (exm_wr_en),
      .exm_dst   (exm_dst),
      .mwb_wr_en (mwb_wr_en),
      .mwb_dst   (mwb_dst),
      .sel       (op_sel[g])
    );

    opfwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (op_sel[g]),
      .rf_val  (op_rf[g]),
      .exm_val (exm_result),
      .wb_val  (wb_val),
      .opnd    (op_out[g])
    );

    // checks on each operand's select and mux output
    always_comb begin
      assert_sel_legal_R9: assert (op_sel[g] != 2'b11);
      if (op_sel[g] == FWD_FROM_EXM) begin
        assert_exm_guard_R1: assert (exm_wr_en && exm_dst != '0 && exm_dst == op_src[g]);
        assert_exm_pick_R6: assert (op_out[g] == exm_result);
      end
      if (op_sel[g] == FWD_FROM_MWB) begin
        assert_mwb_guard_R2: assert (mwb_wr_en && mwb_dst != '0 && mwb_dst == op_src[g]);
        assert_mwb_yield_R3: assert (!(exm_wr_en && exm_dst != '0 && exm_dst == op_src[g]));
        assert_wb_pick_R7: assert (op_out[g] == (mwb_mem_to_reg ? mwb_mem_data : mwb_alu_result));
      end
      if (op_sel[g] == FWD_FROM_RF) begin
        assert_rf_pick_R4: assert (op_out[g] == op_rf[g]);
      end
    end
  end

  always_comb begin
    sel_a  = op_sel[0];
    sel_b  = op_sel[1];
    opnd_a = op_out[0];
    opnd_b = op_out[1];
  end
endmodule

// File: tb/opfwd_unit_test.sv
module opfwd_unit_test;
  logic        clk = 1'b0;
  logic [4:0]  src_a_reg, src_b_reg, exm_dst, mwb_dst;
  logic [31:0] src_a_rf, src_b_rf, exm_result, mwb_alu_result, mwb_mem_data;
  logic        exm_wr_en, mwb_wr_en, mwb_mem_to_reg;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opfwd_unit uut (
    .src_a_reg(src_a_reg), .src_b_reg(src_b_reg),
    .src_a_rf(src_a_rf), .src_b_rf(src_b_rf),
    .exm_wr_en(exm_wr_en), .exm_dst(exm_dst), .exm_result(exm_result),
    .mwb_wr_en(mwb_wr_en), .mwb_dst(mwb_dst), .mwb_mem_to_reg(mwb_mem_to_reg),
    .mwb_alu_result(mwb_alu_result), .mwb_mem_data(mwb_mem_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // behavioural reference: priority by age, register 0 never bypassed
  function automatic logic [1:0] want_sel(input logic [4:0] src);
    if (exm_wr_en && exm_dst != 0 && exm_dst == src) return 2'b10;
    if (mwb_wr_en && mwb_dst != 0 && mwb_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_val(input logic [1:0] s, input logic [31:0] rf);
    if (s == 2'b10) return exm_result;
    if (s == 2'b01) return mwb_mem_to_reg ? mwb_mem_data : mwb_alu_result;
    return rf;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // outputs are combinational (R8): sample half a cycle after driving
  task automatic compare(input string req);
    logic [1:0] ea, eb;
    @(negedge clk);
    ea = want_sel(src_a_reg);
    eb = want_sel(src_b_reg);
    check(req, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    check(req, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    check(req, "opnd_a", opnd_a, want_val(ea, src_a_rf));
    check(req, "opnd_b", opnd_b, want_val(eb, src_b_rf));
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [4:0] ra, input logic [4:0] rb,
                       input logic ew, input logic [4:0] ed,
                       input logic mw, input logic [4:0] md, input logic m2r);
    src_a_reg = ra; src_b_reg = rb;
    exm_wr_en = ew; exm_dst = ed;
    mwb_wr_en = mw; mwb_dst = md; mwb_mem_to_reg = m2r;
  endtask

  initial begin
    src_a_rf = 32'hA0A0_0001; src_b_rf = 32'hB0B0_0002;
    exm_result = 32'hE0E0_0003; mwb_alu_result = 32'hC0C0_0004;
    mwb_mem_data = 32'hD0D0_0005;
    drive(0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1;
    compare("R4 idle");                       // all-zero start state
    drive(3, 7, 1, 3, 0, 0, 0); compare("R1");
    drive(3, 7, 1, 7, 0, 0, 0); compare("R10"); // store data path on B
    drive(3, 7, 0, 0, 1, 3, 0); compare("R2");
    drive(3, 7, 0, 0, 1, 7, 1); compare("R7");
    drive(3, 7, 0, 0, 1, 7, 0); compare("R7 alu");
    drive(5, 5, 1, 5, 1, 5, 1); compare("R3");
    drive(0, 0, 1, 0, 1, 0, 1); compare("R4 reg0");
    drive(4, 4, 0, 4, 0, 4, 1); compare("R4 wr_off");
    drive(6, 9, 1, 6, 1, 9, 1); compare("R5");
    drive(9, 6, 1, 6, 1, 9, 0); compare("R5 swap");
    drive(2, 2, 1, 0, 1, 2, 1); compare("R2 exm_reg0");
    drive(8, 8, 0, 8, 1, 8, 0); compare("R2 exm_off");
    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom));
      src_a_rf = $urandom; src_b_rf = $urandom; exm_result = $urandom;
      mwb_alu_result = $urandom; mwb_mem_data = $urandom;
      compare("R6 R9 sweep");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule